// File: doc/BRIEF.md
# Interrupt Pending and Forwarding Unit

This block gathers interrupt events into a single pending vector and decides where that vector goes. Three sources can raise pending bits: software writes that set bits, interrupt words delivered by the link receiver, and a serial bus error strobe. Software can also clear bits by writing ones to the clear port. The event sources mark bits only. Clearing comes from software or from a finished outbound packet.

A mode input selects the forwarding path. With `local_mode` high, the block drives `local_irq` while any pending bit is set, and software is responsible for clearing. With `local_mode` low, a non-zero pending vector is captured into a snapshot and offered to the link transmitter on a valid/ready stream. After the transmitter accepts the word, it later pulses `tx_done` when the packet has left the wire. The block then clears exactly the bits the snapshot carried. Any bit raised after the capture stays pending and is sent in a later packet.

Back-pressure rules: on the outbound stream, `tx_valid` stays high and `tx_data` stays constant until the cycle in which `tx_ready` is high. A snapshot is never withdrawn, even if `local_mode` changes while it is being offered. On the inbound stream, `rx_ready` is always high, so every `rx_valid` cycle is consumed.

Top module: `irq_pend_fwd`

## Requirements
- R1: A cycle with `sw_set_en` high ORs `sw_set_data` into the pending vector, visible after the next rising edge. Zero bits in the data leave pending bits unchanged.
- R2: A cycle with `rx_valid` high ORs `rx_data` into the pending vector. `rx_ready` is high in every cycle after reset.
- R3: A cycle with `bus_err` high sets pending bit ERR_BIT (default 31, the top bit).
- R4: With `local_mode` at 1, `local_irq` is high exactly when the pending vector is non-zero, and no new outbound word is offered.
- R5: A cycle with `sw_clr_en` high clears every pending bit where `sw_clr_data` has a 1.
- R6: With `local_mode` at 0, the forwarder idle and the pending vector non-zero, the forwarder captures the vector on the next rising edge. `tx_valid` is then high, with `tx_data` equal to the vector as seen at that edge.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` remains high and `tx_data` does not change.
- R8: A `tx_done` pulse after acceptance clears only the captured bits. Bits set after the capture remain pending and are offered next.
- R9: If a bit is set and cleared in the same cycle, it ends up set.
- R10: After reset, the pending vector is zero and both `tx_valid` and `local_irq` are low.
- R11: A `tx_done` pulse when no accepted word is awaiting completion has no effect on the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mode | input | 1 | 1: raise local line; 0: forward to remote end |
| sw_set_en | input | 1 | Software set strobe |
| sw_set_data | input | IRQ_W | Bits to set |
| sw_clr_en | input | 1 | Software clear strobe |
| sw_clr_data | input | IRQ_W | Bits to clear (write one to clear) |
| rx_valid | input | 1 | Received interrupt word valid |
| rx_ready | output | 1 | Receiver word accepted (always high) |
| rx_data | input | IRQ_W | Received interrupt word |
| bus_err | input | 1 | Serial bus error strobe |
| tx_valid | output | 1 | Outbound interrupt word valid |
| tx_ready | input | 1 | Transmitter accepts word |
| tx_data | output | IRQ_W | Outbound interrupt word (snapshot) |
| tx_done | input | 1 | Outbound packet fully sent |
| pend | output | IRQ_W | Current pending vector |
| local_irq | output | 1 | Local interrupt line |

## Verification
The assertions assume that the transmitter pulses `tx_done` only after it has taken a word, and that `tx_ready` is sampled only against a valid offer. The stimulus raises `tx_done` only once per accepted word, except in the dedicated stray-completion case, which is run while no word is outstanding. All inputs are driven on the falling clock edge, so that every strobe spans exactly one rising edge. Mode changes are made only while the forwarder is idle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    FWD_IDLE  = 2'd0,
    FWD_OFFER = 2'd1,
    FWD_SEND  = 2'd2
  } fwd_state_t;
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
  parameter int IRQ_W   = 32,
  parameter int ERR_BIT = 31
) (
  input  logic             sw_set_en,
  input  logic [IRQ_W-1:0] sw_set_data,
  input  logic             sw_clr_en,
  input  logic [IRQ_W-1:0] sw_clr_data,
  input  logic             rx_take,
  input  logic [IRQ_W-1:0] rx_data,
  input  logic             bus_err,
  input  logic [IRQ_W-1:0] fwd_clr,
  output logic [IRQ_W-1:0] set_vec,
  output logic [IRQ_W-1:0] clr_vec
);
  logic [IRQ_W-1:0] err_mask;

  // Map the bus error strobe onto its dedicated pending bit.
  for (genvar i = 0; i < IRQ_W; i++) begin : g_err
    if (i == ERR_BIT) begin : g_hit
      assign err_mask[i] = bus_err;
    end else begin : g_miss
      assign err_mask[i] = 1'b0;
    end
  end

  always_comb begin
    set_vec = err_mask;
    if (sw_set_en) set_vec = set_vec | sw_set_data;
    if (rx_take)   set_vec = set_vec | rx_data;
  end

  always_comb begin
    clr_vec = fwd_clr;
    if (sw_clr_en) clr_vec = clr_vec | sw_clr_data;
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] pend_q
);
  // A set event overrides a clear on the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R9

  AST_ONLY_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0)); // R1

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0)); // R5
endmodule

// File: rtl/irq_fwd_fsm.sv
module irq_fwd_fsm
  import irq_pkg::*;
#(
  parameter int IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             local_mode,
  input  logic [IRQ_W-1:0] pend_q,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [IRQ_W-1:0] tx_data,
  input  logic             tx_done,
  output logic [IRQ_W-1:0] fwd_clr
);
  fwd_state_t       state_q;
  logic [IRQ_W-1:0] snap_q;
  logic             capture;
  logic             finish;

  assign capture = (state_q == FWD_IDLE) && !local_mode && (|pend_q);
  assign finish  = (state_q == FWD_SEND) && tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FWD_IDLE;
      snap_q  <= '0;
    end else begin
      unique case (state_q)
        FWD_IDLE: if (capture) begin
          state_q <= FWD_OFFER;
          snap_q  <= pend_q;
        end
        FWD_OFFER: if (tx_ready) state_q <= FWD_SEND;
        FWD_SEND:  if (tx_done)  state_q <= FWD_IDLE;
        default:   state_q <= FWD_IDLE;
      endcase
    end
  end

  assign tx_valid = (state_q == FWD_OFFER);
  assign tx_data  = snap_q;
  assign fwd_clr  = finish ? snap_q : '0;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

  AST_TX_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data != '0)); // R6

  AST_NO_OFFER_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> !$past(local_mode)); // R4

  AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (state_q == FWD_IDLE) && !tx_valid); // R8

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && state_q != FWD_SEND) |-> (fwd_clr == '0)); // R11
endmodule

// File: rtl/irq_pend_fwd.sv
module irq_pend_fwd #(
  parameter int IRQ_W   = 32,
  parameter int ERR_BIT = IRQ_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             local_mode,
  input  logic             sw_set_en,
  input  logic [IRQ_W-1:0] sw_set_data,
  input  logic             sw_clr_en,
  input  logic [IRQ_W-1:0] sw_clr_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [IRQ_W-1:0] rx_data,
  input  logic             bus_err,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [IRQ_W-1:0] tx_data,
  input  logic             tx_done,
  output logic [IRQ_W-1:0] pend,
  output logic             local_irq
);
  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;
  logic [IRQ_W-1:0] fwd_clr;
  logic [IRQ_W-1:0] pend_q;

  assign rx_ready = rst_n;

  irq_src_merge #(.IRQ_W(IRQ_W), .ERR_BIT(ERR_BIT)) u_merge (
    .sw_set_en   (sw_set_en),
    .sw_set_data (sw_set_data),
    .sw_clr_en   (sw_clr_en),
    .sw_clr_data (sw_clr_data),
    .rx_take     (rx_valid && rx_ready),
    .rx_data     (rx_data),
    .bus_err     (bus_err),
    .fwd_clr     (fwd_clr),
    .set_vec     (set_vec),
    .clr_vec     (clr_vec)
  );

  irq_pend_reg #(.IRQ_W(IRQ_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  irq_fwd_fsm #(.IRQ_W(IRQ_W)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .local_mode (local_mode),
    .pend_q     (pend_q),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_done    (tx_done),
    .fwd_clr    (fwd_clr)
  );

  assign pend      = pend_q;
  assign local_irq = local_mode && (|pend_q);

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> pend[ERR_BIT]); // R3

  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ((pend & $past(rx_data)) == $past(rx_data))); // R2
endmodule

// File: tb/irq_pend_fwd_test.sv
module irq_pend_fwd_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         local_mode;
  logic         sw_set_en;
  logic [W-1:0] sw_set_data;
  logic         sw_clr_en;
  logic [W-1:0] sw_clr_data;
  logic         rx_valid;
  logic         rx_ready;
  logic [W-1:0] rx_data;
  logic         bus_err;
  logic         tx_valid;
  logic         tx_ready;
  logic [W-1:0] tx_data;
  logic         tx_done;
  logic [W-1:0] pend;
  logic         local_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  irq_pend_fwd #(.IRQ_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .local_mode(local_mode),
    .sw_set_en(sw_set_en), .sw_set_data(sw_set_data),
    .sw_clr_en(sw_clr_en), .sw_clr_data(sw_clr_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .bus_err(bus_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_done(tx_done), .pend(pend), .local_irq(local_irq)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_set_en = 0; sw_set_data = '0; sw_clr_en = 0; sw_clr_data = '0;
    rx_valid = 0; rx_data = '0; bus_err = 0; tx_ready = 0; tx_done = 0;
  endtask

  task automatic sw_set(logic [W-1:0] d);
    @(negedge clk); sw_set_en = 1; sw_set_data = d;
    @(negedge clk); sw_set_en = 0; sw_set_data = '0;
  endtask

  task automatic sw_clr(logic [W-1:0] d);
    @(negedge clk); sw_clr_en = 1; sw_clr_data = d;
    @(negedge clk); sw_clr_en = 0; sw_clr_data = '0;
  endtask

  task automatic t_reset();
    check("R10 pend", pend, '0);
    check("R10 tx_valid", W'(tx_valid), '0);
    check("R10 local_irq", W'(local_irq), '0);
  endtask

  task automatic t_sw_set();
    sw_set(32'h0000_0011);
    check("R1 set", pend, 32'h0000_0011);
    sw_set(32'h0000_0000);
    check("R1 zero write no effect", pend, 32'h0000_0011);
    check("R4 local_irq high", W'(local_irq), 1);
    check("R4 no offer", W'(tx_valid), 0);
    sw_clr(32'h0000_0001);
    check("R5 clear one bit", pend, 32'h0000_0010);
    sw_clr(32'hFFFF_FFFF);
    check("R5 clear all", pend, '0);
    check("R4 local_irq low", W'(local_irq), 0);
  endtask

  task automatic t_rx_set();
    check("R2 rx_ready", W'(rx_ready), 1);
    @(negedge clk); rx_valid = 1; rx_data = 32'h0000_0F00;
    @(negedge clk); rx_valid = 0; rx_data = '0;
    check("R2 rx set", pend, 32'h0000_0F00);
    sw_clr(32'hFFFF_FFFF);
  endtask

  task automatic t_bus_err();
    @(negedge clk); bus_err = 1;
    @(negedge clk); bus_err = 0;
    check("R3 error bit", pend, 32'h8000_0000);
    sw_clr(32'hFFFF_FFFF);
  endtask

  task automatic t_same_cycle();
    sw_set(32'h0000_0018);
    @(negedge clk);
    sw_set_en = 1; sw_set_data = 32'h0000_0008;
    sw_clr_en = 1; sw_clr_data = 32'h0000_0018;
    @(negedge clk); idle_inputs();
    check("R9 set wins", pend, 32'h0000_0008);
    sw_clr(32'hFFFF_FFFF);
  endtask

  task automatic t_stray_done();
    sw_set(32'h0000_0300);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    check("R11 stray done ignored", pend, 32'h0000_0300);
    sw_clr(32'hFFFF_FFFF);
  endtask

  task automatic t_remote();
    @(negedge clk); local_mode = 0; sw_set_en = 1; sw_set_data = 32'h0000_00A5;
    @(negedge clk); sw_set_en = 0; sw_set_data = '0;
    check("R6 not yet offered", W'(tx_valid), 0);
    @(negedge clk);
    check("R6 offer valid", W'(tx_valid), 1);
    check("R6 offer data", tx_data, 32'h0000_00A5);
    check("R4 no local irq remote", W'(local_irq), 0);
    sw_set(32'h0000_0100);
    check("R7 held valid", W'(tx_valid), 1);
    check("R7 held data", tx_data, 32'h0000_00A5);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    check("R8 accepted", W'(tx_valid), 0);
    check("R8 still pending before done", pend, 32'h0000_01A5);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    check("R8 captured bits cleared", pend, 32'h0000_0100);
    @(negedge clk);
    check("R8 next offer valid", W'(tx_valid), 1);
    check("R8 next offer data", tx_data, 32'h0000_0100);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0; tx_done = 1;
    @(negedge clk); tx_done = 0;
    check("R8 all cleared", pend, '0);
    @(negedge clk);
    check("R6 idle with empty vector", W'(tx_valid), 0);
    local_mode = 1;
  endtask

  initial begin
    rst_n = 0; local_mode = 1; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sw_set();
    t_rx_set();
    t_bus_err();
    t_same_cycle();
    t_stray_done();
    t_remote();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule